// File: doc/BRIEF.md
# Watchdog Timer with Vector-Shared Service Address

This block is a watchdog for a small 8-bit microcontroller bus. A free-running prescaler divides the clock by a power of two. Each prescaler wrap advances a timeout counter. When the timeout counter rolls over, the block raises a one-clock reset request. Software keeps the system alive by writing any byte to the top address of the map, 0xFFFF. The same location also holds the low byte of the reset vector.

Because of this sharing, a bus read of 0xFFFF never returns watchdog state. It passes through the vector byte that program memory supplies on `vec_byte_i`. A bus write there only restarts the timeout, and the written data is dropped. During a vector fetch, the prescaler is cleared. A configuration bit can switch the watchdog off. Once a request has been issued, the block stays quiet until the external reset has been asserted and released. The block has no interrupt output.

Top module: `wdog_vecclr`

## Requirements
- R1: While `rst_ni` is low, both counters are cleared and `reset_req_o` is 0. The first request appears exactly 2^(PRESCALE_BITS+TIMEOUT_BITS) rising edges after release. With PRESCALE_BITS=3 and TIMEOUT_BITS=3 that is 64 edges.
- R2: The request is high for exactly one clock cycle. It is raised on the edge where the prescaler and the timeout counter both wrap.
- R3: After a request, no further request is made until `rst_ni` has been asserted and released again.
- R4: A write (`bus_wr_i`=1) to address 0xFFFF with any data clears both counters. No request follows that edge. The next request comes 2^(PRESCALE_BITS+TIMEOUT_BITS) edges after the write edge.
- R5: A write to any address other than 0xFFFF has no effect on when the request appears.
- R6: When `vec_fetch_i` is 1 and the address is 0xFFFE or 0xFFFF, only the prescaler is cleared. The timeout count is kept, and that edge gives no prescaler tick.
  - Example with both widths 3: a fetch on edge 20 after release moves the request from edge 64 to edge 68.
  - A fetch indication with any other address has no effect.
- R7: While `disable_i` is 1, both counters are held at zero and no request is made. The first edge after `disable_i` falls starts a full period.
- R8: In a cycle with `bus_rd_i`=1 and address 0xFFFF, `rd_data_o` equals `vec_byte_i` in that same cycle. In every other cycle `rd_data_o` is 0. Reads do not change timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| disable_i | input | 1 | Configuration bit that turns the watchdog off |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | DATA_W | Write data (ignored) |
| vec_fetch_i | input | 1 | Marks a reset vector fetch cycle |
| vec_byte_i | input | DATA_W | Vector low byte from program memory |
| rd_data_o | output | DATA_W | Read data, valid in the read cycle |
| reset_req_o | output | 1 | One-cycle reset request |

## Verification
A wrong count or a missed clear in either counter shows up only as a request that comes too early, too late, twice or not at all. The smallest error shifts the request edge by a single cycle. The bench therefore uses small counter widths so that a full period is 64 edges. It checks the exact edge of every request against a behavioural model, so any timing fault appears within one period. A decode fault on the shared address shows up in the same cycle as a wrong `rd_data_o`.

// File: rtl/wdog_vecclr_pkg.sv
package wdog_vecclr_pkg;
   typedef struct packed {
      logic svc_wr;   // service write strobe
      logic svc_rd;   // shared-address read
      logic vec_clr;  // vector fetch seen on vector addresses
   } wdog_dec_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned WIDTH = 12
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   output logic tick_o
);
   generate
      if (WIDTH == 0) begin : g_bypass
         assign tick_o = ~clr_i;
      end else begin : g_count
         logic [WIDTH-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)    cnt_q <= '0;
            else if (clr_i) cnt_q <= '0;
            else            cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = ~clr_i & (&cnt_q);
      end
   endgenerate
endmodule

// File: rtl/wdog_timeout.sv
module wdog_timeout #(
   parameter int unsigned WIDTH = 6
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic tick_i,
   output logic expire_o
);
   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (tick_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = tick_i & ~clr_i & (&cnt_q);
endmodule

// File: rtl/wdog_busdec.sv
module wdog_busdec
   import wdog_vecclr_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic              fetch_i,
   input  logic [DATA_W-1:0] vec_byte_i,
   output wdog_dec_t         dec_o,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam logic [ADDR_W-1:0] SVC_ADDR = '1;

   logic svc_hit, vec_hit;

   assign svc_hit = (addr_i == SVC_ADDR);
   assign vec_hit = &addr_i[ADDR_W-1:1];

   assign dec_o.svc_wr  = wr_i & svc_hit;
   assign dec_o.svc_rd  = rd_i & svc_hit;
   assign dec_o.vec_clr = fetch_i & vec_hit;

   assign rd_data_o = dec_o.svc_rd ? vec_byte_i : '0;
endmodule

// File: rtl/wdog_vecclr.sv
module wdog_vecclr
   import wdog_vecclr_pkg::*;
#(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned PRESCALE_BITS = 12,
   parameter int unsigned TIMEOUT_BITS  = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              disable_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic              vec_fetch_i,
   input  logic [DATA_W-1:0] vec_byte_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              reset_req_o
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("wdog_vecclr: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("wdog_vecclr: DATA_W must be at least 1");
      end
      if (TIMEOUT_BITS < 1) begin : g_bad_to
         $error("wdog_vecclr: TIMEOUT_BITS must be at least 1");
      end
   endgenerate

   wdog_dec_t dec;
   logic      fired_q, req_q;
   logic      hold, pre_clr, to_clr, tick, expire;
   logic      unused_wdata;

   assign unused_wdata = ^bus_wdata_i;

   wdog_busdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .addr_i     (bus_addr_i),
      .wr_i       (bus_wr_i),
      .rd_i       (bus_rd_i),
      .fetch_i    (vec_fetch_i),
      .vec_byte_i (vec_byte_i),
      .dec_o      (dec),
      .rd_data_o  (rd_data_o)
   );

   assign hold    = disable_i | fired_q;
   assign to_clr  = hold | dec.svc_wr;
   assign pre_clr = to_clr | dec.vec_clr;

   wdog_prescaler #(.WIDTH(PRESCALE_BITS)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (pre_clr),
      .tick_o (tick)
   );

   wdog_timeout #(.WIDTH(TIMEOUT_BITS)) u_to (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (to_clr),
      .tick_i   (tick),
      .expire_o (expire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fired_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         fired_q <= fired_q | expire;
         req_q   <= expire;
      end
   end

   assign reset_req_o = req_q;
endmodule

// File: rtl/wdog_vecclr_chk.sv
module wdog_vecclr_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              disable_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_wr_i,
   input logic              bus_rd_i,
   input logic              vec_fetch_i,
   input logic [DATA_W-1:0] vec_byte_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              reset_req_o
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   logic seen_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          seen_q <= 1'b0;
      else if (reset_req_o) seen_q <= 1'b1;
   end

   // R2
   req_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reset_req_o |=> !reset_req_o);

   // R3
   no_second_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reset_req_o |-> !seen_q);

   // R4
   svc_write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == TOP_ADDR) |=> !reset_req_o);

   // R7
   disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disable_i |=> !reset_req_o);

   // R8
   read_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && bus_addr_i == TOP_ADDR) |-> rd_data_o == vec_byte_i);

   // R8
   read_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_rd_i && bus_addr_i == TOP_ADDR) |-> rd_data_o == '0);
endmodule

bind wdog_vecclr wdog_vecclr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .disable_i   (disable_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wr_i    (bus_wr_i),
   .bus_rd_i    (bus_rd_i),
   .vec_fetch_i (vec_fetch_i),
   .vec_byte_i  (vec_byte_i),
   .rd_data_o   (rd_data_o),
   .reset_req_o (reset_req_o)
);

// File: tb/wdog_vecclr_tb_top.sv
`timescale 1ns/100ps
module wdog_vecclr_tb_top;
   localparam int P = 3;
   localparam int T = 3;
   localparam int PERIOD = 1 << (P + T);
   localparam int PMAX = (1 << P) - 1;
   localparam int TMAX = (1 << T) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dis = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic       wr = 1'b0, rd = 1'b0, vf = 1'b0;
   logic [7:0] wdata = 8'h00, vbyte = 8'h00;
   logic [7:0] rdata;
   logic       req;

   int checks = 0, fails = 0, cyc = 0;
   int m_pre = 0, m_to = 0, m_fired = 0, m_req = 0;

   always #2 clk = ~clk;

   wdog_vecclr #(.ADDR_W(16), .DATA_W(8), .PRESCALE_BITS(P), .TIMEOUT_BITS(T)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .disable_i(dis), .bus_addr_i(addr),
      .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .vec_fetch_i(vf),
      .vec_byte_i(vbyte), .rd_data_o(rdata), .reset_req_o(req));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // behavioural reference model, compared every clock
   always @(posedge clk) begin
      int nreq;
      cyc++;
      nreq = 0;
      if (!rst_n) begin
         m_pre = 0; m_to = 0; m_fired = 0;
      end else if (dis || m_fired != 0 || (wr && addr == 16'hFFFF)) begin
         m_pre = 0; m_to = 0;
      end else if (vf && addr >= 16'hFFFE) begin
         m_pre = 0;
      end else if (m_pre == PMAX) begin
         m_pre = 0;
         if (m_to == TMAX) begin m_to = 0; nreq = 1; end
         else m_to++;
      end else begin
         m_pre++;
      end
      m_req = nreq;
      if (nreq != 0) m_fired = 1;
      #0.5;
      chk(req == m_req[0], "R2 model request", int'(req), m_req);
      chk(rdata == ((rd && addr == 16'hFFFF) ? vbyte : 8'h00), "R8 model read data",
          int'(rdata), int'((rd && addr == 16'hFFFF) ? vbyte : 8'h00));
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic do_reset(input bit keep_dis);
      @(negedge clk); rst_n = 1'b0; dis = keep_dis;
      idle(3); #1;
      chk(req == 1'b0, "R1 request low in reset", int'(req), 0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic wait_req(input int maxc, output int at);
      at = -1;
      for (int i = 0; i < maxc; i++) begin
         @(posedge clk); #1;
         if (req) begin at = cyc; return; end
      end
   endtask

   task automatic count_req(input int n, output int cnt);
      cnt = 0;
      repeat (n) begin @(posedge clk); #1; if (req) cnt++; end
   endtask

   task automatic bus_op(input logic [15:0] a, input bit w, input bit f,
                         input logic [7:0] d, output int edge_no);
      @(negedge clk); addr = a; wr = w; vf = f; wdata = d;
      @(posedge clk); #1; edge_no = cyc;
      @(negedge clk); wr = 1'b0; vf = 1'b0; addr = 16'h0000;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int start, at, cnt, e;
      // R1 / R2: first timeout and pulse width
      do_reset(1'b0); start = cyc;
      wait_req(200, at);
      chk(at == start + PERIOD, "R1 first request edge", at - start, PERIOD);
      @(posedge clk); #1;
      chk(req == 1'b0, "R2 request one cycle", int'(req), 0);
      // R3: silent after firing
      count_req(150, cnt);
      chk(cnt == 0, "R3 no request after firing", cnt, 0);
      do_reset(1'b0); start = cyc;
      wait_req(200, at);
      chk(at == start + PERIOD, "R3 fires again after reset", at - start, PERIOD);

      // R4: service write, data A5 then 00
      do_reset(1'b0);
      idle(39); bus_op(16'hFFFF, 1'b1, 1'b0, 8'hA5, e);
      wait_req(200, at);
      chk(at == e + PERIOD, "R4 write A5 restarts", at - e, PERIOD);
      do_reset(1'b0);
      idle(60); bus_op(16'hFFFF, 1'b1, 1'b0, 8'h00, e);
      wait_req(200, at);
      chk(at == e + PERIOD, "R4 write 00 restarts", at - e, PERIOD);

      // R5: write to another address
      do_reset(1'b0); start = cyc;
      idle(30); bus_op(16'hFFFE, 1'b1, 1'b0, 8'h55, e);
      wait_req(200, at);
      chk(at == start + PERIOD, "R5 other write ignored", at - start, PERIOD);

      // R6: vector fetch on edge 20 clears only the prescaler
      do_reset(1'b0); start = cyc;
      idle(19); bus_op(16'hFFFE, 1'b0, 1'b1, 8'h00, e);
      chk(e == start + 20, "R6 fetch edge placement", e - start, 20);
      wait_req(200, at);
      chk(at == start + 68, "R6 fetch delays request", at - start, 68);
      do_reset(1'b0); start = cyc;
      idle(19); bus_op(16'h1234, 1'b0, 1'b1, 8'h00, e);
      wait_req(200, at);
      chk(at == start + PERIOD, "R6 fetch elsewhere ignored", at - start, PERIOD);

      // R7: disable
      do_reset(1'b1);
      count_req(200, cnt);
      chk(cnt == 0, "R7 no request while disabled", cnt, 0);
      @(negedge clk); dis = 1'b0; start = cyc;
      wait_req(200, at);
      chk(at == start + PERIOD, "R7 full period after enable", at - start, PERIOD);
      do_reset(1'b0);
      idle(40); @(negedge clk); dis = 1'b1;
      idle(5); @(negedge clk); dis = 1'b0; start = cyc;
      wait_req(200, at);
      chk(at == start + PERIOD, "R7 mid-period disable restarts", at - start, PERIOD);

      // R8: reads of the shared address
      do_reset(1'b0); start = cyc;
      @(negedge clk); rd = 1'b1; addr = 16'hFFFF; vbyte = 8'h3C; #0.5;
      chk(rdata == 8'h3C, "R8 read returns vector byte", int'(rdata), 'h3C);
      @(negedge clk); addr = 16'hFFFE; #0.5;
      chk(rdata == 8'h00, "R8 read other address", int'(rdata), 0);
      @(negedge clk); rd = 1'b0; addr = 16'hFFFF; #0.5;
      chk(rdata == 8'h00, "R8 no strobe gives zero", int'(rdata), 0);
      @(negedge clk); rd = 1'b1; vbyte = 8'hC3;
      idle(10); @(negedge clk); rd = 1'b0; addr = 16'h0000;
      wait_req(200, at);
      chk(at == start + PERIOD, "R8 reads leave timing", at - start, PERIOD);

      idle(2);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule